// File: doc/BRIEF.md
# Paired Floating-Point Register File

This block stores the floating-point operands of a 32-bit processor: thirty-two registers of 32 bits each. Every access is either word-wide or pair-wide. A word access touches the one register it names. A pair access names an even register and also covers the odd register above it, so a 64-bit double-precision value is carried as two adjacent words. No register is tied to zero. Register 0 holds whatever was last written to it, the same as every other register.

There are two combinational read ports and one clocked write port. Each port has its own width select. A pair access that names an odd register is refused: the port raises its error flag, a read returns zero, and a write leaves every register as it was. The 64-bit data buses follow memory order. Bits [31:0] are the word at byte offset 0 and go to the even register. Bits [63:32] are the word at byte offset 4 and go to the odd register. This means a double load can write its memory image straight in, and a double store can take a pair read straight out.

A word move from the integer side is a word write whose low 32 bits are stored unchanged. A word move to the integer side is a word read that returns the raw bits of the register.

Top module: `fp_pair_regfile`

## Requirements
- R1: While rst_n is low at a rising clock edge, all 32 registers are cleared to zero, and every read after that returns zero until a new write.
- R2: A word write (wr_en=1, wr_dbl=0) stores wr_data[31:0] unchanged into register wr_idx, for any index 0 to 31 including 0. wr_data[63:32] is ignored.
- R3: A word read (dbl=0) returns the raw bits of the named register on data[31:0] and zero on data[63:32], with the bad flag low.
- R4: A pair write (wr_dbl=1, even wr_idx=n) updates both registers at the same clock edge: wr_data[31:0] goes into register n and wr_data[63:32] goes into register n+1.
- R5: A pair read (dbl=1, even idx=n) returns {register n+1, register n}, with register n on data[31:0].
- R6: A pair access with an odd index is illegal. A read raises its bad flag and returns zero data. A write raises wr_bad combinationally and modifies no register.
- R7: Reads are combinational. A read of a register that is being written in the same cycle returns the old value until the clock edge, and returns the new value after it.
- R8: The two read ports are independent. Each port can read a different register, at a different width, in the same cycle.
- R9: With wr_en low, no register changes. A word write changes only the register it names and leaves the other register of its pair unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_dbl | input | 1 | Write width: 0 word, 1 pair |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data; [31:0] goes to the even/named register, [63:32] to the odd register |
| wr_bad | output | 1 | Write is an illegal odd-index pair access |
| rd_a_dbl | input | 1 | Read port A width: 0 word, 1 pair |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 64 | Read port A data |
| rd_a_bad | output | 1 | Read port A is an illegal odd-index pair access |
| rd_b_dbl | input | 1 | Read port B width: 0 word, 1 pair |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 64 | Read port B data |
| rd_b_bad | output | 1 | Read port B is an illegal odd-index pair access |

## Verification
The bench goes after five corner cases.
- Register 0: if it were wrongly tied to zero, it would read back zero instead of the stored value.
- Word order in a pair: if the halves were swapped, the offset-0 and offset-4 words would come back in the wrong registers.
- Odd-index pair writes: a bad design would corrupt the odd register or its neighbours instead of leaving all registers untouched.
- A word write inside a pair: if it spilled over, the partner register would change.
- A read of the register being written in the same cycle: a design with bypass or early update would show the new value before the clock edge.

The bench also resets in the middle of the run, so a design that cleared only part of the array would leave stale data behind.

// File: rtl/fprf_pkg.sv
// Package fprf_pkg
// Shared access-width encoding for the paired register file.
// Assumes one select bit per port: 0 selects a word, 1 selects an even/odd pair.
package fprf_pkg;
    typedef enum logic {
        ACC_WORD = 1'b0,
        ACC_PAIR = 1'b1
    } acc_width_e;
endpackage

// File: rtl/fprf_spec_check.sv
// Module fprf_spec_check
// Decodes a register specifier and an access width into the low and high
// register indices of the access. Flags a pair access that names an odd register.
// Assumes the register count is a power of two, so the odd partner of an
// even index is always in range.
module fprf_spec_check
    import fprf_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             dbl,
    output logic             illegal,
    output logic [IDX_W-1:0] lo_idx,
    output logic [IDX_W-1:0] hi_idx
);
    acc_width_e width;

    // Decode the width, the legality and both register indices.
    always_comb begin
        width   = acc_width_e'(dbl);
        illegal = (width == ACC_PAIR) && idx[0];
        hi_idx  = {idx[IDX_W-1:1], 1'b1};
        if (width == ACC_PAIR) begin
            lo_idx = {idx[IDX_W-1:1], 1'b0};
        end else begin
            lo_idx = idx;
        end
    end
endmodule

// File: rtl/fprf_bank.sv
// Module fprf_bank
// The register array itself. Each register has two write lanes: the low lane
// (word or even half of a pair) and the high lane (odd half of a pair).
// Assumes the write controller never drives both lanes at the same index.
module fprf_bank #(
    parameter int NREG   = 32,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_en,
    input  logic [IDX_W-1:0]  lo_idx,
    input  logic [WORD_W-1:0] lo_data,
    input  logic              hi_en,
    input  logic [IDX_W-1:0]  hi_idx,
    input  logic [WORD_W-1:0] hi_data,
    output logic [WORD_W-1:0] q [NREG]
);
    // R9
    lane_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en && hi_en) |-> (lo_idx != hi_idx));

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic lo_hit;
        logic hi_hit;

        // Match this register against both write lanes.
        always_comb begin
            lo_hit = lo_en && (lo_idx == IDX_W'(i));
            hi_hit = hi_en && (hi_idx == IDX_W'(i));
        end

        // Hold, clear on reset, or load from whichever lane addresses this register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (lo_hit) begin
                q[i] <= lo_data;
            end else if (hi_hit) begin
                q[i] <= hi_data;
            end
        end

        // R9
        untouched_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(lo_en && (lo_idx == IDX_W'(i))) && !(hi_en && (hi_idx == IDX_W'(i)))
            |=> $stable(q[i]));
    end
endmodule

// File: rtl/fprf_write_ctrl.sv
// Module fprf_write_ctrl
// Turns the write request into lane enables for the bank. A word write uses
// the low lane only. A legal pair write uses both lanes: the offset-0 word goes
// to the even register and the offset-4 word to the odd register. An illegal
// pair write enables neither lane.
module fprf_write_ctrl #(
    parameter int NREG   = 32,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                wr_en,
    input  logic                wr_dbl,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [2*WORD_W-1:0] wr_data,
    output logic                wr_bad,
    output logic                lo_en,
    output logic [IDX_W-1:0]    lo_idx,
    output logic [WORD_W-1:0]   lo_data,
    output logic                hi_en,
    output logic [IDX_W-1:0]    hi_idx,
    output logic [WORD_W-1:0]   hi_data
);
    logic illegal;

    fprf_spec_check #(.IDX_W(IDX_W)) u_spec (
        .idx     (wr_idx),
        .dbl     (wr_dbl),
        .illegal (illegal),
        .lo_idx  (lo_idx),
        .hi_idx  (hi_idx)
    );

    // Gate the lanes with the request and the legality of the specifier.
    always_comb begin
        wr_bad  = wr_en && illegal;
        lo_en   = wr_en && !illegal;
        hi_en   = wr_en && wr_dbl && !illegal;
        lo_data = wr_data[WORD_W-1:0];
        hi_data = wr_data[2*WORD_W-1:WORD_W];
    end
endmodule

// File: rtl/fprf_read_port.sv
// Module fprf_read_port
// One combinational read port. A word read returns the register in the low
// half of the bus with zero above it. A pair read returns {odd, even}. An
// illegal pair read returns zero and raises the bad flag.
module fprf_read_port #(
    parameter int NREG   = 32,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [WORD_W-1:0]   q [NREG],
    input  logic [IDX_W-1:0]    idx,
    input  logic                dbl,
    output logic [2*WORD_W-1:0] data,
    output logic                bad
);
    logic             illegal;
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;

    fprf_spec_check #(.IDX_W(IDX_W)) u_spec (
        .idx     (idx),
        .dbl     (dbl),
        .illegal (illegal),
        .lo_idx  (lo_idx),
        .hi_idx  (hi_idx)
    );

    // Select and arrange the words of the access onto the bus.
    always_comb begin
        bad = illegal;
        if (illegal) begin
            data = '0;
        end else if (dbl) begin
            data = {q[hi_idx], q[lo_idx]};
        end else begin
            data = {{WORD_W{1'b0}}, q[lo_idx]};
        end
    end
endmodule

// File: rtl/fp_pair_regfile.sv
// Module fp_pair_regfile
// Floating-point register file with two read ports and one write port. Each
// port accesses either one word or an even/odd pair. Reads are combinational
// and show the state before the write in the same cycle takes effect.
// Assumes a synchronous active-low reset, and a register count that is a
// power of two.
module fp_pair_regfile #(
    parameter int NREG   = 32,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(NREG),
    localparam int BUS_W = 2 * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_dbl,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BUS_W-1:0] wr_data,
    output logic             wr_bad,
    input  logic             rd_a_dbl,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [BUS_W-1:0] rd_a_data,
    output logic             rd_a_bad,
    input  logic             rd_b_dbl,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [BUS_W-1:0] rd_b_data,
    output logic             rd_b_bad
);
    logic              lo_en;
    logic [IDX_W-1:0]  lo_idx;
    logic [WORD_W-1:0] lo_data;
    logic              hi_en;
    logic [IDX_W-1:0]  hi_idx;
    logic [WORD_W-1:0] hi_data;
    logic [WORD_W-1:0] q [NREG];

    fprf_write_ctrl #(.NREG(NREG), .WORD_W(WORD_W)) u_wctl (
        .wr_en   (wr_en),
        .wr_dbl  (wr_dbl),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_bad  (wr_bad),
        .lo_en   (lo_en),
        .lo_idx  (lo_idx),
        .lo_data (lo_data),
        .hi_en   (hi_en),
        .hi_idx  (hi_idx),
        .hi_data (hi_data)
    );

    fprf_bank #(.NREG(NREG), .WORD_W(WORD_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_en   (lo_en),
        .lo_idx  (lo_idx),
        .lo_data (lo_data),
        .hi_en   (hi_en),
        .hi_idx  (hi_idx),
        .hi_data (hi_data),
        .q       (q)
    );

    fprf_read_port #(.NREG(NREG), .WORD_W(WORD_W)) u_rd_a (
        .q    (q),
        .idx  (rd_a_idx),
        .dbl  (rd_a_dbl),
        .data (rd_a_data),
        .bad  (rd_a_bad)
    );

    fprf_read_port #(.NREG(NREG), .WORD_W(WORD_W)) u_rd_b (
        .q    (q),
        .idx  (rd_b_idx),
        .dbl  (rd_b_dbl),
        .data (rd_b_data),
        .bad  (rd_b_bad)
    );

    // R6
    odd_pair_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_dbl && rd_a_idx[0]) |-> (rd_a_bad && rd_a_data == '0));

    // R6
    odd_pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dbl && wr_idx[0]) |-> wr_bad);

    // R3
    word_read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_b_dbl |-> (rd_b_data[BUS_W-1:WORD_W] == '0 && !rd_b_bad));

    // R4
    pair_write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && wr_dbl && !wr_idx[0])
         && rd_a_dbl && rd_a_idx == $past(wr_idx))
        |-> (rd_a_data == $past(wr_data)));

    // R2
    word_write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && !wr_dbl)
         && !rd_b_dbl && rd_b_idx == $past(wr_idx))
        |-> (rd_b_data[WORD_W-1:0] == $past(wr_data[WORD_W-1:0])));
endmodule

// File: tb/fp_pair_regfile_test.sv
`timescale 1ns/1ps
module fp_pair_regfile_test;
    typedef struct packed {
        logic        wen;
        logic        wdbl;
        logic [4:0]  widx;
        logic [63:0] wdata;
        logic        rdbl;
        logic [4:0]  ridx;
        logic [63:0] exp;
        logic        expbad;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 5'd0,  64'h0000_0000_DEAD_BEEF, 1'b0, 5'd0,  64'h0000_0000_DEAD_BEEF, 1'b0},
        '{1'b1, 1'b0, 5'd31, 64'h1234_5678_CAFE_F00D, 1'b0, 5'd31, 64'h0000_0000_CAFE_F00D, 1'b0},
        '{1'b1, 1'b1, 5'd2,  64'h1111_2222_3333_4444, 1'b1, 5'd2,  64'h1111_2222_3333_4444, 1'b0},
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd3,  64'h0000_0000_1111_2222, 1'b0},
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd2,  64'h0000_0000_3333_4444, 1'b0},
        '{1'b1, 1'b1, 5'd5,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'd5,  64'h0,                   1'b0},
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd4,  64'h0,                   1'b0},
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd6,  64'h0,                   1'b0},
        '{1'b1, 1'b0, 5'd3,  64'h9999_9999_AAAA_5555, 1'b1, 5'd2,  64'hAAAA_5555_3333_4444, 1'b0},
        '{1'b1, 1'b1, 5'd30, 64'h0BAD_0BAD_F00D_F00D, 1'b1, 5'd30, 64'h0BAD_0BAD_F00D_F00D, 1'b0},
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd31, 64'h0000_0000_0BAD_0BAD, 1'b0},
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd3,  64'h0,                   1'b1},
        '{1'b0, 1'b1, 5'd0,  64'h5555_5555_5555_5555, 1'b0, 5'd0,  64'h0000_0000_DEAD_BEEF, 1'b0},
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd3,  64'h0000_0000_AAAA_5555, 1'b0}
    };

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic        wr_dbl;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;
    logic        wr_bad;
    logic        rd_a_dbl;
    logic [4:0]  rd_a_idx;
    logic [63:0] rd_a_data;
    logic        rd_a_bad;
    logic        rd_b_dbl;
    logic [4:0]  rd_b_idx;
    logic [63:0] rd_b_data;
    logic        rd_b_bad;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    fp_pair_regfile uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_dbl    (wr_dbl),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .wr_bad    (wr_bad),
        .rd_a_dbl  (rd_a_dbl),
        .rd_a_idx  (rd_a_idx),
        .rd_a_data (rd_a_data),
        .rd_a_bad  (rd_a_bad),
        .rd_b_dbl  (rd_b_dbl),
        .rd_b_idx  (rd_b_idx),
        .rd_b_data (rd_b_data),
        .rd_b_bad  (rd_b_bad)
    );

    // 125 MHz clock.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_write();
        wr_en   = 1'b0;
        wr_dbl  = 1'b0;
        wr_idx  = '0;
        wr_data = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle_write();
        rd_a_dbl = 1'b0; rd_a_idx = '0;
        rd_b_dbl = 1'b0; rd_b_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset, on both ports.
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(31 - i);
            #1;
            check("R1 port A", rd_a_data, 64'h0);
            check("R1 port B", rd_b_data, 64'h0);
        end

        // Vector table: optional write, then a read on port A in the next cycle.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            wr_en   = VECS[v].wen;
            wr_dbl  = VECS[v].wdbl;
            wr_idx  = VECS[v].widx;
            wr_data = VECS[v].wdata;
            #1;
            check("R6 wr_bad", {63'h0, wr_bad},
                  {63'h0, VECS[v].wen & VECS[v].wdbl & VECS[v].widx[0]});
            @(negedge clk);
            idle_write();
            rd_a_dbl = VECS[v].rdbl;
            rd_a_idx = VECS[v].ridx;
            #1;
            check("R2/R3/R4/R5/R6/R9 table data", rd_a_data, VECS[v].exp);
            check("R3/R6 table bad", {63'h0, rd_a_bad}, {63'h0, VECS[v].expbad});
        end

        // R7: a read of the register being written sees the old value before the edge.
        @(negedge clk);
        wr_en = 1'b1; wr_dbl = 1'b0; wr_idx = 5'd7; wr_data = 64'h0000_0000_7777_7777;
        rd_a_dbl = 1'b0; rd_a_idx = 5'd7;
        #1;
        check("R7 old value before edge", rd_a_data, 64'h0);
        @(posedge clk);
        #1;
        check("R7 new value after edge", rd_a_data, 64'h0000_0000_7777_7777);
        @(negedge clk);
        idle_write();

        // R8: both ports read different registers at different widths.
        rd_a_dbl = 1'b1; rd_a_idx = 5'd2;
        rd_b_dbl = 1'b0; rd_b_idx = 5'd31;
        #1;
        check("R8 port A pair", rd_a_data, 64'hAAAA_5555_3333_4444);
        check("R8 port B word", rd_b_data, 64'h0000_0000_0BAD_0BAD);
        rd_b_dbl = 1'b1; rd_b_idx = 5'd7;
        #1;
        check("R8 port B odd pair bad", {63'h0, rd_b_bad}, 64'h1);
        check("R8 port A unaffected", rd_a_data, 64'hAAAA_5555_3333_4444);

        // R9: wr_en low with data present leaves the register alone.
        @(negedge clk);
        wr_en = 1'b0; wr_dbl = 1'b1; wr_idx = 5'd30; wr_data = 64'h1234_1234_1234_1234;
        @(negedge clk);
        idle_write();
        rd_a_dbl = 1'b1; rd_a_idx = 5'd30;
        #1;
        check("R9 disabled write", rd_a_data, 64'h0BAD_0BAD_F00D_F00D);

        // R1: a reset in the middle of the run clears the populated registers.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_a_dbl = 1'b1; rd_a_idx = 5'd2;
        rd_b_dbl = 1'b1; rd_b_idx = 5'd30;
        #1;
        check("R1 mid-run reset pair 2", rd_a_data, 64'h0);
        check("R1 mid-run reset pair 30", rd_b_data, 64'h0);
        rd_a_dbl = 1'b0; rd_a_idx = 5'd0;
        rd_b_dbl = 1'b0; rd_b_idx = 5'd7;
        #1;
        check("R1 mid-run reset reg 0", rd_a_data, 64'h0);
        check("R1 mid-run reset reg 7", rd_b_data, 64'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule